// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block feeds a transmit path from a circular list of buffer descriptors that software keeps in memory. After software programs the ring start address and writes the activation register, the engine walks the descriptors in order. For each one it reads the descriptor, copies the buffer it points to into a transmit FIFO one 32-bit word at a time, and then writes the descriptor back with its ownership bit cleared. This hands the descriptor back to software.

A frame can span several descriptors. When the descriptor that closes a frame completes, the engine follows the data with one control word so that the downstream MAC sees the frame's CRC options. The engine stops only after it has found a descriptor still owned by software on two consecutive reads. If an activation write arrived while the engine was busy, it makes one further read before stopping.

Memory traffic uses a request/acknowledge word port. Every FIFO entry carries a tag that tells plain data, the final data word of a frame and the control word apart.

Top module: `txring_walker`

## Requirements
- R1: While reset is held and on the cycles after it is released, neither `mem_req` nor `fifo_push` is asserted until an activation write arrives.
- R2: A write with `reg_sel`=0 sets the ring start address with its two low bits forced to zero, so the first descriptor read after the next activation uses the 4-byte-aligned address.
- R3: Any write with `reg_sel`=1 starts descriptor fetching from the current ring position, whatever data value is written.
- R4: A descriptor is two words. The control word is at the ring position: bit 31 = owned by hardware, bit 29 = wrap, bit 27 = frame end, bit 26 = append CRC, bit 25 = force bad CRC, bits 15:0 = byte length. The buffer address is at position+4, with its low two bits ignored. The engine reads ceil(length/4) buffer words at rising addresses, and the following descriptor sits 8 bytes later.
- R5: After a descriptor with the wrap bit set, the next descriptor read is at the ring start address.
- R6: When a control word reads with bit 31 = 0, the engine reads the same address once more. If the bit is 1 this time, it processes that descriptor. If it is still 0, the engine makes no further memory request until the next activation write.
- R7: After a descriptor's last buffer word has been pushed, the engine writes the control word back to the descriptor's address with bit 31 cleared and all other bits unchanged.
- R8: FIFO tags are 0 = data, 1 = final data word of a frame, 2 = control word. After the final data word of a frame-end descriptor, exactly one extra entry with tag 2 carries that descriptor's control word as read (bit 31 set). Descriptors without the frame-end bit produce only tag-0 entries.
- R9: `fifo_push` is asserted only in a cycle that follows a cycle with `fifo_full` low. Stalls lose no data and do not change the order of the data.
- R10: An activation write that arrives while the engine is busy adds one further read of a software-owned descriptor before the engine goes idle.
- R11: Once `mem_req` is raised, it stays high, and `mem_addr`, `mem_we` and `mem_wdata` stay unchanged, until a cycle with `mem_ack` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = ring start address, 1 = activation |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid |
| mem_rdata | input | 32 | Read data |
| fifo_push | output | 1 | FIFO write strobe |
| fifo_tag | output | 2 | Entry type: 0 data, 1 final data, 2 control |
| fifo_data | output | 32 | FIFO entry payload |
| fifo_full | input | 1 | FIFO cannot take a push next cycle |

## Verification
The bench goes after the ownership re-check from three sides. A descriptor that software hands over between the two reads must be processed. One that stays software-owned must end in exactly two reads and then silence. A kick that arrives mid-frame must raise that count to three. An engine that skipped the re-read, or forgot the late kick, would either stall on data that is ready or spin on an empty ring.

The bench also sends the ring past a wrap descriptor and checks that reads return to the start address; a design that kept adding 8 would run off the ring. It uses lengths that are not word multiples, where a design that truncated instead of rounding up would drop the tail word. It holds the FIFO full for most cycles, where an engine that ignored back-pressure would lose or reorder words. It builds a frame split across two descriptors, where a control word after the first descriptor would give a wrong entry count.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int R_BIT = 31;
  localparam int W_BIT = 29;
  localparam int L_BIT = 27;

  typedef enum logic [1:0] {
    TAG_DATA = 2'd0,
    TAG_LAST = 2'd1,
    TAG_CTRL = 2'd2
  } tag_e;

  typedef enum logic [2:0] {
    S_IDLE, S_D0, S_D1, S_BUF, S_PUSH, S_WB, S_CTRL
  } st_e;
endpackage

// File: rtl/txring_kick_track.sv
module txring_kick_track (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  input  logic engine_idle,
  input  logic consume,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else if (engine_idle) pend <= 1'b0;
    else pend <= kick | (pend & ~consume);
  end

  // R10
  pend_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(kick));
endmodule

// File: rtl/txring_ring_ptr.sv
module txring_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_wr,
  input  logic [AW-1:0] base_in,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] cur
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);
  logic [AW-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      cur  <= '0;
    end else if (base_wr) begin
      base <= base_in & ALIGN_MASK;
      cur  <= base_in & ALIGN_MASK;
    end else if (adv) begin
      cur <= wrap ? base : cur + AW'(STEP);
    end
  end

  // R5
  wrap_to_base_chk: assert property (@(posedge clk) disable iff (rst)
    adv && wrap && !base_wr |=> cur == $past(base));
endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txring_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          fifo_push,
  output logic [1:0]    fifo_tag,
  output logic [DW-1:0] fifo_data,
  input  logic          fifo_full
);
  localparam int CNT_W = LEN_W - 1;
  localparam int WORD_BYTES = DW / 8;
  localparam logic [DW-1:0] OWN_MASK = ~(DW'(1) << R_BIT);

  st_e             st;
  logic [DW-1:0]   d0;
  logic [AW-1:0]   bufp;
  logic [CNT_W-1:0] left;
  logic [DW-1:0]   word;
  logic            seen_zero;
  logic            pend, adv, consume, kick, base_wr;
  logic [AW-1:0]   cur;
  logic [LEN_W:0]  len_up;

  assign kick    = reg_wr & reg_sel;
  assign base_wr = reg_wr & ~reg_sel;
  assign len_up  = {1'b0, d0[LEN_W-1:0]} + (LEN_W+1)'(3);

  always_comb begin
    adv = 1'b0;
    consume = 1'b0;
    if (st == S_WB && mem_req && mem_ack && !d0[L_BIT]) adv = 1'b1;
    if (st == S_CTRL && !fifo_full) adv = 1'b1;
    if (st == S_D0 && mem_req && mem_ack && !mem_rdata[R_BIT] && seen_zero && pend)
      consume = 1'b1;
  end

  txring_kick_track i_kick (
    .clk(clk), .rst(rst), .kick(kick), .engine_idle(st == S_IDLE),
    .consume(consume), .pend(pend)
  );

  txring_ring_ptr #(.AW(AW), .STEP(2 * WORD_BYTES)) i_ptr (
    .clk(clk), .rst(rst), .base_wr(base_wr), .base_in(reg_wdata[AW-1:0]),
    .adv(adv), .wrap(d0[W_BIT]), .cur(cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      fifo_push <= 1'b0;
      fifo_tag  <= TAG_DATA;
      fifo_data <= '0;
      d0        <= '0;
      bufp      <= '0;
      left      <= '0;
      word      <= '0;
      seen_zero <= 1'b0;
    end else begin
      fifo_push <= 1'b0;
      case (st)
        S_IDLE: if (kick || pend) begin
          st        <= S_D0;
          seen_zero <= 1'b0;
        end
        S_D0: if (!mem_req) begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= cur;
        end else if (mem_ack) begin
          mem_req <= 1'b0;
          d0      <= mem_rdata;
          if (mem_rdata[R_BIT]) begin
            seen_zero <= 1'b0;
            st        <= S_D1;
          end else if (!seen_zero) begin
            seen_zero <= 1'b1;
          end else if (!pend) begin
            st <= S_IDLE;
          end
        end
        S_D1: if (!mem_req) begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= cur + AW'(WORD_BYTES);
        end else if (mem_ack) begin
          mem_req <= 1'b0;
          bufp    <= mem_rdata[AW-1:0] & ~AW'(3);
          left    <= len_up[LEN_W:2];
          st      <= (d0[LEN_W-1:0] == '0) ? S_WB : S_BUF;
        end
        S_BUF: if (!mem_req) begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= bufp;
        end else if (mem_ack) begin
          mem_req <= 1'b0;
          word    <= mem_rdata;
          st      <= S_PUSH;
        end
        S_PUSH: if (!fifo_full) begin
          fifo_push <= 1'b1;
          fifo_data <= word;
          fifo_tag  <= (left == CNT_W'(1) && d0[L_BIT]) ? TAG_LAST : TAG_DATA;
          bufp      <= bufp + AW'(WORD_BYTES);
          left      <= left - CNT_W'(1);
          st        <= (left == CNT_W'(1)) ? S_WB : S_BUF;
        end
        S_WB: if (!mem_req) begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= cur;
          mem_wdata <= d0 & OWN_MASK;
        end else if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          st      <= d0[L_BIT] ? S_CTRL : S_D0;
        end
        S_CTRL: if (!fifo_full) begin
          fifo_push <= 1'b1;
          fifo_data <= d0;
          fifo_tag  <= TAG_CTRL;
          st        <= S_D0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00);
  // R7
  wb_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> !mem_wdata[R_BIT]);
  // R9
  push_full_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> !$past(fifo_full));
  // R8
  ctrl_owned_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_push && fifo_tag == TAG_CTRL |-> fifo_data[R_BIT]);
endmodule

// File: tb/test_txring_walker.sv
module test_txring_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h100;
  localparam int NVEC = 5;
  localparam logic [15:0] VEC_LEN [NVEC] = '{16'd4, 16'd5, 16'd8, 16'd13, 16'd1};
  localparam int VEC_WORDS [NVEC] = '{1, 2, 2, 4, 1};

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic fifo_push, fifo_full = 0;
  logic [1:0] fifo_tag;
  logic [31:0] fifo_data;

  txring_walker i_txring_walker (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fifo_push(fifo_push),
    .fifo_tag(fifo_tag), .fifo_data(fifo_data), .fifo_full(fifo_full)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, done = 0;
  logic [31:0] mem [256];
  int rd_cnt [256];
  logic [31:0] log_addr [128];
  int nlog = 0;
  logic [31:0] push_data [64];
  logic [1:0] push_tag [64];
  int npush = 0;
  int lat = 1, wcnt = 0, full_mode = 0, cyc = 0;
  int full_bad = 0, addr_bad = 0, flip_idx = -1;
  logic [31:0] hold_addr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (fifo_push) begin
      if (fifo_full) full_bad++;
      if (npush < 64) begin
        push_data[npush] = fifo_data;
        push_tag[npush] = fifo_tag;
      end
      npush++;
    end
    fifo_full = (full_mode != 0) ? (cyc % 3 != 2) : 1'b0;
    if (mem_ack) begin
      mem_ack = 0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt > 0 && mem_addr != hold_addr) addr_bad++;
      hold_addr = mem_addr;
      if (wcnt >= lat) begin
        mem_ack = 1;
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        else begin
          mem_rdata = mem[mem_addr[9:2]];
          rd_cnt[mem_addr[9:2]]++;
          if (nlog < 128) log_addr[nlog] = mem_addr;
          nlog++;
          if (flip_idx == int'(mem_addr[9:2])) begin
            mem[flip_idx][31] = 1'b1;
            flip_idx = -1;
          end
        end
      end else wcnt++;
    end else wcnt = 0;
  end

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    int g = 0;
    while (q < 30 && g < 5000) begin
      @(negedge clk);
      if (mem_req) q = 0; else q++;
      g++;
    end
  endtask

  task automatic clear_logs();
    for (int k = 0; k < 256; k++) rd_cnt[k] = 0;
    nlog = 0;
    npush = 0;
  endtask

  function automatic int didx(input int s);
    return int'(BASE >> 2) + s * 2;
  endfunction

  function automatic logic [31:0] mk_w0(input int s, input bit r, input bit l, input logic [15:0] len);
    return (32'(r) << 31) | ((s == 3) ? 32'h2000_0000 : 32'h0) | (32'(l) << 27) | 32'h0400_0000 | {16'h0, len};
  endfunction

  task automatic put_desc(input int s, input logic [31:0] w0, input logic [31:0] ptr, input int nw, input logic [31:0] seed);
    mem[didx(s)] = w0;
    mem[didx(s) + 1] = ptr;
    for (int k = 0; k < nw; k++) mem[int'(ptr[9:2]) + k] = seed + 32'(k);
  endtask

  int slot = 0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (done == 0) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w0, ptr;
    int bad, s;
    for (int k = 0; k < 256; k++) mem[k] = 0;
    clear_logs();
    // R1: quiet through reset and after release
    bad = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (mem_req || fifo_push) bad++;
    end
    rst = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (mem_req || fifo_push) bad++;
    end
    chk(bad == 0, "R1 reset quiet", 32'(bad), 0);

    // R2: base with low bits set
    reg_write(0, BASE | 32'h3);

    // table of single-descriptor frames
    for (int i = 0; i < NVEC; i++) begin
      s = slot;
      w0 = mk_w0(s, 1, 1, VEC_LEN[i]);
      ptr = 32'h200 + 32'(i) * 32'h40 + 32'h1;
      put_desc(s, w0, ptr, VEC_WORDS[i], 32'hA000_0000 + 32'(i) * 32'h100);
      clear_logs();
      reg_write(1, (i == 2) ? 32'h0 : 32'hDEAD_BEEF ^ 32'(i)); // R3 data ignored
      wait_quiet();
      chk(log_addr[0] == BASE + 32'(s * 8), "R2 R3 R5 first fetch address", log_addr[0], BASE + 32'(s * 8));
      chk(log_addr[1] == BASE + 32'(s * 8 + 4) && log_addr[2] == (ptr & ~32'h3), "R4 pointer and buffer address", log_addr[2], ptr & ~32'h3);
      chk(npush == VEC_WORDS[i] + 1, "R4 R8 entry count", 32'(npush), 32'(VEC_WORDS[i] + 1));
      bad = 0;
      for (int k = 0; k < VEC_WORDS[i]; k++) begin
        if (push_data[k] != 32'hA000_0000 + 32'(i) * 32'h100 + 32'(k)) bad++;
        if (push_tag[k] != ((k == VEC_WORDS[i] - 1) ? 2'd1 : 2'd0)) bad++;
      end
      chk(bad == 0, "R4 R8 data words and tags", 32'(bad), 0);
      chk(push_data[VEC_WORDS[i]] == w0 && push_tag[VEC_WORDS[i]] == 2'd2, "R8 control word", push_data[VEC_WORDS[i]], w0);
      chk(mem[didx(s)] == (w0 & 32'h7FFF_FFFF), "R7 writeback", mem[didx(s)], w0 & 32'h7FFF_FFFF);
      slot = (s + 1) % 4;
      chk(rd_cnt[didx(slot)] == 2, "R6 R5 double read of empty descriptor", 32'(rd_cnt[didx(slot)]), 2);
    end

    // R8: frame split over two descriptors
    s = slot;
    put_desc(s, mk_w0(s, 1, 0, 16'd4), 32'h380, 1, 32'hB000_0000);
    w0 = mk_w0(s + 1, 1, 1, 16'd8);
    put_desc(s + 1, w0, 32'h3A0, 2, 32'hB100_0000);
    clear_logs();
    reg_write(1, 32'h5);
    wait_quiet();
    chk(npush == 4, "R8 split frame entry count", 32'(npush), 4);
    chk(push_tag[0] == 0 && push_tag[1] == 0 && push_tag[2] == 1 && push_tag[3] == 2, "R8 split frame tags",
        {24'h0, push_tag[0], push_tag[1], push_tag[2], push_tag[3]}, 32'h0000_0006);
    chk(push_data[3] == w0 && push_data[0] == 32'hB000_0000, "R8 split frame control word", push_data[3], w0);
    chk(mem[didx(s)][31] == 0 && mem[didx(s + 1)][31] == 0, "R7 both descriptors returned", mem[didx(s)], 0);
    slot = (s + 2) % 4;

    // R6: ownership granted between the two reads
    s = slot;
    w0 = mk_w0(s, 0, 1, 16'd12);
    put_desc(s, w0, 32'h3C0, 3, 32'hC000_0000);
    clear_logs();
    flip_idx = didx(s);
    reg_write(1, 32'h0);
    wait_quiet();
    chk(rd_cnt[didx(s)] == 2, "R6 re-read of same descriptor", 32'(rd_cnt[didx(s)]), 2);
    chk(npush == 4 && push_data[3] == (w0 | 32'h8000_0000), "R6 processed after re-read", push_data[3], w0 | 32'h8000_0000);
    slot = (s + 1) % 4;
    chk(rd_cnt[didx(slot)] == 2 && slot == 0, "R5 wrap then empty", 32'(rd_cnt[didx(slot)]), 2);

    // R6 R3: stays idle without a kick
    bad = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (mem_req) bad++;
    end
    chk(bad == 0, "R6 idle until activation", 32'(bad), 0);

    // R10: kick while busy
    s = slot;
    lat = 3;
    put_desc(s, mk_w0(s, 1, 1, 16'd16), 32'h300, 4, 32'hD000_0000);
    clear_logs();
    reg_write(1, 32'h1);
    repeat (6) @(negedge clk);
    reg_write(1, 32'h2);
    wait_quiet();
    slot = (s + 1) % 4;
    chk(rd_cnt[didx(slot)] == 3, "R10 extra re-check", 32'(rd_cnt[didx(slot)]), 3);
    lat = 1;

    // R9: heavy back-pressure
    s = slot;
    full_mode = 1;
    w0 = mk_w0(s, 1, 1, 16'd16);
    put_desc(s, w0, 32'h340, 4, 32'hE000_0000);
    clear_logs();
    reg_write(1, 32'h3);
    wait_quiet();
    repeat (10) @(negedge clk);
    full_mode = 0;
    bad = 0;
    for (int k = 0; k < 4; k++) if (push_data[k] != 32'hE000_0000 + 32'(k)) bad++;
    chk(npush == 5 && bad == 0 && push_data[4] == w0, "R9 no loss under stall", 32'(npush), 5);
    chk(full_bad == 0, "R9 push only after not-full", 32'(full_bad), 0);
    slot = (s + 1) % 4;

    // R11
    chk(addr_bad == 0, "R11 request held stable", 32'(addr_bad), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule